// File: doc/BRIEF.md
# Periodic Wakeup Timer

This block is a down-counting wakeup timer for the always-on clock domain of a low-power chip. It counts ticks from one of two sources. The first is the domain clock divided by 2, 4, 8 or 16. The second is a separate once-per-second tick. Each time the count runs out, the block raises a wakeup event flag. That flag drives an external pin, and it also drives an interrupt line when the interrupt is enabled.

Software uses a small register-style write port. The expected order is as follows. First clear the run bit. Then wait for the configuration-permitted status. Then program the tick source and the reload count. Finally set the interrupt enable and the run bit.

The configuration-permitted status returns only after two ticks of the selected counting source have passed since the disable. This stands for the crossing into the slow domain. While the status is low, writes to the tick source or the reload count are dropped.

The event flag is cleared by writing a 0 to its bit. Writing a 1 to that bit leaves the flag unchanged.

Top module: `wake_timer`

## Requirements
- R1: After reset, wakeFlag, wakeIrq and wakePin are 0, cfgOk is 1, and the timer is stopped.
- R2: The select field is bits [2:0] at address 1. Values 0 to 3 make the counting tick the clock divided by 2, 4, 8 and 16 respectively.
- R3: Select values 4 to 7 (bit 2 set) make the counting tick the secTick input pulse.
- R4: The reload count is written at address 2 and is CNT_W bits wide (17 by default). Once running, the block expires every (reload + 1) counting ticks.
- R5: Each expiry sets wakeFlag on the next clock edge. An expiry in the same cycle as a clear write wins over the clear. The flag stays set across later expiries until it is cleared.
- R6: A write to address 3 with bit 0 equal to 0 clears wakeFlag. A write to address 3 with bit 0 equal to 1 leaves wakeFlag unchanged.
- R7: The control register is at address 0, with bit 0 as run and bit 1 as interrupt enable. wakeIrq equals wakeFlag AND the interrupt enable. wakePin follows wakeFlag.
- R8: cfgOk drops to 0 on the edge that sets run. After run is cleared, cfgOk returns to 1 once two counting ticks have passed.
- R9: Writes to the select field or the reload count are ignored while cfgOk is 0.
- R10: Setting run while the timer is stopped loads the counter from the reload count. Writing run=1 again while the timer is running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock; also the source of the divided ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse per second from the calendar logic |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 select, 2 reload, 3 status |
| wrData | input | CNT_W | Write data |
| wakeFlag | output | 1 | Wakeup event flag |
| wakeIrq | output | 1 | Level interrupt: flag gated by the interrupt enable |
| wakePin | output | 1 | External pin copy of the flag |
| cfgOk | output | 1 | High when the select and reload writes are accepted |

## Verification
The hardest situation to reach from the ports is the short window just after a disable. In that window run is already low but cfgOk has not yet risen, so a reload write must still be dropped. The bench issues that reload write on the very edge after the disable. It then checks that the period measured after re-enabling is still the old one.

A second hard case is a clear write that lands on the same edge as an expiry. The bench reaches it by writing a clear on every cycle while it measures the period. Each expiry must then still show up as a one-cycle flag pulse, and the spacing of those pulses gives the period. Random select values, including the second-tick mode, and random reload counts are checked against periods computed in the bench.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int SEL_W = 3;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IRQ_BIT = 1;
  localparam int STAT_FLAG_BIT = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_SEL    = 2'd1,
    ADDR_RELOAD = 2'd2,
    ADDR_STAT   = 2'd3
  } wtAddr_e;

  typedef struct packed {
    logic loadCnt;
    logic tickEn;
  } wtStrobe_t;
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int DIV_STAGES = 4,
  localparam int IDX_W = (DIV_STAGES > 1) ? $clog2(DIV_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] selDiv,
  output logic             divTick
);
  logic [DIV_STAGES-1:0] preCnt;
  logic [DIV_STAGES-1:0] tapTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // tap k pulses once every 2^(k+1) clocks
  for (genvar k = 0; k < DIV_STAGES; k++) begin : g_tap
    assign tapTick[k] = &preCnt[k:0];
  end

  assign divTick = tapTick[selDiv];
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             divTick,
  input  logic             secTick,
  input  logic             expire,
  output wtStrobe_t        strobe,
  output logic [SEL_W-1:0] cfgSel,
  output logic [CNT_W-1:0] cfgReload,
  output logic             runEn,
  output logic             irqEn,
  output logic             wakeFlag,
  output logic             cfgOk
);
  wtAddr_e addr;
  logic ctrlWr, selWr, reloadWr, flagClr, startRun, tick;
  logic [SYNC_STAGES-1:0] syncQ;

  assign addr     = wtAddr_e'(wrAddr);
  assign ctrlWr   = wrEn && (addr == ADDR_CTRL);
  assign selWr    = wrEn && (addr == ADDR_SEL);
  assign reloadWr = wrEn && (addr == ADDR_RELOAD);
  assign flagClr  = wrEn && (addr == ADDR_STAT) && !wrData[STAT_FLAG_BIT];
  assign startRun = ctrlWr && wrData[CTRL_RUN_BIT] && !runEn;
  assign tick     = cfgSel[SEL_W-1] ? secTick : divTick;
  assign cfgOk    = syncQ[SYNC_STAGES-1];

  assign strobe.loadCnt = startRun;
  assign strobe.tickEn  = runEn && tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      irqEn     <= 1'b0;
      cfgSel    <= '0;
      cfgReload <= '0;
      wakeFlag  <= 1'b0;
      syncQ     <= '1;
    end else begin
      if (ctrlWr) begin
        runEn <= wrData[CTRL_RUN_BIT];
        irqEn <= wrData[CTRL_IRQ_BIT];
      end
      if (selWr && cfgOk)    cfgSel    <= wrData[SEL_W-1:0];
      if (reloadWr && cfgOk) cfgReload <= wrData;
      if (expire)       wakeFlag <= 1'b1;
      else if (flagClr) wakeFlag <= 1'b0;
      if (startRun || runEn) syncQ <= '0;
      else if (tick)         syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  wtStrobe_t        strobe,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic atZero;

  assign atZero = (cnt == '0);
  assign expire = strobe.tickEn && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadCnt) cnt <= reload;
    else if (strobe.tickEn)  cnt <= atZero ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int SYNC_STAGES = 2,
  localparam int DIV_STAGES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             wakeFlag,
  output logic             wakeIrq,
  output logic             wakePin,
  output logic             cfgOk
);
  wtStrobe_t strobe;
  logic [SEL_W-1:0] cfgSel;
  logic [CNT_W-1:0] cfgReload;
  logic runEn, irqEn, expire, divTick;

  wt_prescale #(.DIV_STAGES(DIV_STAGES)) u_pre (
    .clk(clk), .rstN(rstN), .selDiv(cfgSel[1:0]), .divTick(divTick)
  );

  wt_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .divTick(divTick), .secTick(secTick), .expire(expire), .strobe(strobe),
    .cfgSel(cfgSel), .cfgReload(cfgReload), .runEn(runEn), .irqEn(irqEn),
    .wakeFlag(wakeFlag), .cfgOk(cfgOk)
  );

  wt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reload(cfgReload), .expire(expire)
  );

  assign wakeIrq = wakeFlag && irqEn;
  assign wakePin = wakeFlag;
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic             wrBit0,
  input logic             wakeFlag,
  input logic             wakeIrq,
  input logic             cfgOk,
  input logic             expire,
  input logic             runEn,
  input logic [2:0]       cfgSel,
  input logic [CNT_W-1:0] cfgReload
);
  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> wakeFlag);
  // R5
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> wakeFlag);
  // R5
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(expire));
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && !wrBit0 && !expire) |=> !wakeFlag);
  // R8
  run_locks_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> !cfgOk);
  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOk |=> ($stable(cfgReload) && $stable(cfgSel)));
endmodule

bind wake_timer wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
  .wakeFlag(wakeFlag), .wakeIrq(wakeIrq), .cfgOk(cfgOk), .expire(expire),
  .runEn(runEn), .cfgSel(cfgSel), .cfgReload(cfgReload)
);

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 17;

  logic clk = 1'b0, rstN = 1'b0, secTick = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic wakeFlag, wakeIrq, wakePin, cfgOk;
  int checks = 0, errors = 0, secP = 4, secCnt = 0;
  bit finished = 0;

  wake_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wakeFlag(wakeFlag), .wakeIrq(wakeIrq),
    .wakePin(wakePin), .cfgOk(cfgOk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // once-per-"second" pulse, secP clocks apart
  always @(negedge clk) begin
    secCnt  <= (secCnt >= secP - 1) ? 0 : secCnt + 1;
    secTick <= (secCnt == secP - 1);
  end

  function automatic int expPeriod(int sel, int reload, int sp);
    return (reload + 1) * ((sel >= 4) ? sp : (2 << sel));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = CNT_W'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitCfg();
    for (int i = 0; i < 400 && !cfgOk; i++) idle(1);
  endtask

  // clear-writes every cycle; flag rises mark expiries; all intervals must match
  task automatic measure(string req, int ncyc, int exp, int disturbAt);
    int rises[$];
    bit prev = wakeFlag;
    bit ok = 1;
    int bad = exp;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      wrEn = 1'b1;
      if (i == disturbAt) begin wrAddr = 2'd0; wrData = CNT_W'(3); end
      else                begin wrAddr = 2'd3; wrData = '0; end
      @(posedge clk); #1;
      if (wakeFlag && !prev) rises.push_back(i);
      prev = wakeFlag;
    end
    wrEn = 1'b0;
    if (rises.size() < 3) begin ok = 0; bad = rises.size(); end
    else for (int j = 1; j < rises.size(); j++)
      if (rises[j] - rises[j-1] != exp) begin ok = 0; bad = rises[j] - rises[j-1]; end
    chk(ok, req, bad, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk(!wakeFlag && !wakeIrq && !wakePin, "R1 outputs", wakeFlag, 0);
    chk(cfgOk, "R1 cfgOk", cfgOk, 1);
    idle(10);
    chk(!wakeFlag, "R1 stopped", wakeFlag, 0);

    // R2 R4 R10: div2, reload 5, re-write run mid-count
    wr(1, 0); wr(2, 5); wr(0, 3);
    chk(!cfgOk, "R8 running", cfgOk, 0);
    measure("R10 rewrite run", 90, expPeriod(0, 5, 0), 40);

    // R9 writes while running are dropped
    wr(2, 2); wr(1, 1);
    measure("R9 running", 80, expPeriod(0, 5, 0), -1);

    // R8 R9 sync window after disable
    wr(0, 0);
    chk(!cfgOk, "R8 after disable", cfgOk, 0);
    wr(2, 9);
    idle(4);
    chk(cfgOk, "R8 two ticks", cfgOk, 1);
    wr(0, 3);
    measure("R9 sync window", 80, expPeriod(0, 5, 0), -1);

    // R2 R3 R4 random
    void'($urandom(32'h5eed1234));
    for (int it = 0; it < 10; it++) begin
      int sel = $urandom % 6;
      int rl  = $urandom % 12;
      int ep;
      wr(0, 0);
      waitCfg();
      if (sel == 5) sel = 7;
      secP = 3 + ($urandom % 4);
      ep = expPeriod(sel, rl, secP);
      wr(1, sel); wr(2, rl); wr(0, 3);
      measure((sel >= 4) ? "R3 sec tick" : "R2 R4 divided", 4 * ep + 20, ep, -1);
    end

    // R5 R6 R7 flag and interrupt
    wr(0, 0); waitCfg();
    wr(1, 0); wr(2, 1); wr(3, 0); wr(0, 3);
    idle(20);
    chk(wakeFlag, "R5 sticky", wakeFlag, 1);
    chk(wakeIrq && wakePin, "R7 irq/pin", wakeIrq, 1);
    wr(0, 2);
    wr(3, 1);
    chk(wakeFlag, "R6 write one", wakeFlag, 1);
    wr(0, 0);
    chk(!wakeIrq && wakeFlag, "R7 irq gated", wakeIrq, 0);
    wr(3, 0);
    chk(!wakeFlag && !wakePin, "R6 clear", wakeFlag, 0);
    idle(20);
    chk(!wakeFlag, "R6 stays clear", wakeFlag, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule